// File: doc/BRIEF.md
# Lane Compare and Reduce Unit

This unit takes two 128-bit integer vectors and compares them lane by lane. The lane width is chosen per operation: 8, 16, 32 or 64 bits. The comparison can test equality, inequality or ordering, and ordering can be signed or unsigned. The result is a compact predicate mask with one bit per lane, so the number of meaningful bits follows the number of lanes.

The same unit also works on predicate masks. It can combine two masks bitwise, invert a mask, or reduce a mask to a single any-true or all-true bit. It can build a mask from a scalar, which sets every lane true when the scalar is nonzero and every lane false when it is zero. For every operation, the resulting mask is also returned as a full-width vector in which each lane is filled with all ones or all zeros.

One operation may be issued per clock. Results appear one cycle later, marked by a valid flag.

Top module: `lane_cmp_unit`

## Requirements
- R1: After reset, outValid, outMask, outBit and outVec are all zero.
- R2: outValid is high in exactly the cycle after a cycle with inValid high. The registered outputs then reflect that operation.
- R3: laneSize 0, 1, 2 and 3 select lanes of 8, 16, 32 and 64 bits, giving 16, 8, 4 and 2 lanes. Lane n occupies bits n*w upward and maps to outMask bit n. Mask bits at or above the lane count are always zero.
- R4: opSel 0 (equal) and opSel 1 (not equal) give the same result whatever the value of signedCmp. Within the active lanes, not-equal is the exact inverse of equal.
- R5: The ordering codes compare vecA against vecB in each lane: opSel 2 is less-than, 3 is less-or-equal, 4 is greater-than and 5 is greater-or-equal. When signedCmp is 1 the lanes are two's complement; when it is 0 they are unsigned.
- R6: opSel 6, 7 and 8 give the lane-wise AND, OR and XOR of maskA and maskB. opSel 9 gives the inverse of maskA. Only active lanes can be set.
- R7: opSel 10 sets outBit when any active lane of maskA is 1. opSel 11 sets outBit only when every active lane of maskA is 1. For both codes, outMask and outVec are zero. For every other code, outBit is 0.
- R8: opSel 12 returns the active lanes of maskA as outMask. For every operation, each lane of outVec is all ones when its mask bit is 1 and all zeros otherwise.
- R9: opSel 13 sets all active lanes true when scalarIn is nonzero, including a scalar whose only set bits are high. When scalarIn is zero, all lanes are false.
- R10: opSel 14 and 15 produce a zero mask, a zero bit and a zero vector, with outValid still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code |
| laneSize | input | 2 | Lane width select |
| signedCmp | input | 1 | Ordering compares as two's complement |
| vecA | input | 128 | First integer vector |
| vecB | input | 128 | Second integer vector |
| maskA | input | 16 | First predicate mask |
| maskB | input | 16 | Second predicate mask |
| scalarIn | input | 32 | Scalar for mask splat |
| outValid | output | 1 | Result valid |
| outMask | output | 16 | Per-lane result mask |
| outBit | output | 1 | Reduction result |
| outVec | output | 128 | Mask expanded to full lanes |

## Verification
In every cycle, two functions of this unit operate together. Lane-width trimming clears mask bits above the lane count, and at the same time either a reduction or the vector expansion uses the trimmed mask. To provoke this, operations are issued back to back with laneSize changing from one cycle to the next. The input masks carry stray bits above the active lanes, and some idle cycles are mixed in. A behavioural model in the bench computes the expected mask, reduction bit and expanded vector for each operation. All three are compared on the clock after issue, so a stray high bit that leaks into an any-true, an all-true or an expanded lane shows up as a mismatch.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  typedef enum logic [3:0] {
    OP_EQ    = 4'd0,
    OP_NE    = 4'd1,
    OP_LT    = 4'd2,
    OP_LE    = 4'd3,
    OP_GT    = 4'd4,
    OP_GE    = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_NOT   = 4'd9,
    OP_ANY   = 4'd10,
    OP_ALL   = 4'd11,
    OP_PASS  = 4'd12,
    OP_SPLAT = 4'd13
  } lcrOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic cmpEq;
    logic cmpLt;
    logic cmpInv;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doNot;
    logic doAny;
    logic doAll;
    logic doPass;
    logic doSplat;
  } lcrStrobe_t;

endpackage

// File: rtl/lcr_ctrl.sv
module lcr_ctrl
  import lcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opSel,
  output lcrStrobe_t strb,
  output logic       outValid
);

  always_comb begin
    strb = '0;
    strb.load = inValid;
    case (lcrOp_e'(opSel))
      OP_EQ:    strb.cmpEq = 1'b1;
      OP_NE:    begin strb.cmpEq = 1'b1; strb.cmpInv = 1'b1; end
      OP_LT:    strb.cmpLt = 1'b1;
      OP_LE:    begin strb.cmpLt = 1'b1; strb.cmpEq = 1'b1; end
      OP_GT:    begin strb.cmpLt = 1'b1; strb.cmpEq = 1'b1; strb.cmpInv = 1'b1; end
      OP_GE:    begin strb.cmpLt = 1'b1; strb.cmpInv = 1'b1; end
      OP_AND:   strb.doAnd = 1'b1;
      OP_OR:    strb.doOr = 1'b1;
      OP_XOR:   strb.doXor = 1'b1;
      OP_NOT:   strb.doNot = 1'b1;
      OP_ANY:   strb.doAny = 1'b1;
      OP_ALL:   strb.doAll = 1'b1;
      OP_PASS:  strb.doPass = 1'b1;
      OP_SPLAT: strb.doSplat = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/lcr_datapath.sv
module lcr_datapath
  import lcr_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int NUM_SIZES  = 4,
  parameter int SCALAR_W   = 32,
  localparam int MASK_W    = VEC_W / MIN_LANE_W,
  localparam int SZ_W      = $clog2(NUM_SIZES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcrStrobe_t        strb,
  input  logic [SZ_W-1:0]   laneSize,
  input  logic              signedCmp,
  input  logic [VEC_W-1:0]  vecA,
  input  logic [VEC_W-1:0]  vecB,
  input  logic [MASK_W-1:0] maskA,
  input  logic [MASK_W-1:0] maskB,
  input  logic [SCALAR_W-1:0] scalarIn,
  output logic [MASK_W-1:0] outMask,
  output logic              outBit,
  output logic [VEC_W-1:0]  outVec
);

  logic [NUM_SIZES-1:0][MASK_W-1:0] eqBy, ltBy, actBy;
  logic [NUM_SIZES-1:0][VEC_W-1:0]  expBy;
  logic [MASK_W-1:0] eqSel, ltSel, actSel, cmpBase, rawMask, nextMask;
  logic              nextBit;
  logic [VEC_W-1:0]  nextVec;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LB = MIN_LANE_W << s;
    localparam int NL = VEC_W / LB;
    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
      if (i < NL) begin : g_live
        logic [LB-1:0] aL, bL;
        assign aL = vecA[i*LB +: LB];
        assign bL = vecB[i*LB +: LB];
        assign eqBy[s][i]  = (aL == bL);
        // signs differ under signed view: the negative one is smaller
        assign ltBy[s][i]  = (signedCmp && (aL[LB-1] != bL[LB-1])) ? aL[LB-1] : (aL < bL);
        assign actBy[s][i] = 1'b1;
      end else begin : g_dead
        assign eqBy[s][i]  = 1'b0;
        assign ltBy[s][i]  = 1'b0;
        assign actBy[s][i] = 1'b0;
      end
    end
    for (genvar j = 0; j < VEC_W; j++) begin : g_exp
      assign expBy[s][j] = nextMask[j / LB];
    end
  end

  assign eqSel  = eqBy[laneSize];
  assign ltSel  = ltBy[laneSize];
  assign actSel = actBy[laneSize];

  always_comb begin
    cmpBase = ({MASK_W{strb.cmpEq}} & eqSel) | ({MASK_W{strb.cmpLt}} & ltSel);
    rawMask = '0;
    if (strb.cmpEq | strb.cmpLt) rawMask = strb.cmpInv ? ~cmpBase : cmpBase;
    if (strb.doAnd)   rawMask = maskA & maskB;
    if (strb.doOr)    rawMask = maskA | maskB;
    if (strb.doXor)   rawMask = maskA ^ maskB;
    if (strb.doNot)   rawMask = ~maskA;
    if (strb.doPass)  rawMask = maskA;
    if (strb.doSplat) rawMask = {MASK_W{|scalarIn}};
    nextMask = rawMask & actSel;
    nextBit  = (strb.doAny & (|(maskA & actSel))) |
               (strb.doAll & (&(maskA | ~actSel)));
  end

  assign nextVec = expBy[laneSize];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMask <= '0;
      outBit  <= 1'b0;
      outVec  <= '0;
    end else if (strb.load) begin
      outMask <= nextMask;
      outBit  <= nextBit;
      outVec  <= nextVec;
    end
  end

endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit
  import lcr_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int NUM_SIZES  = 4,
  parameter int SCALAR_W   = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic [3:0]                       opSel,
  input  logic [$clog2(NUM_SIZES)-1:0]     laneSize,
  input  logic                             signedCmp,
  input  logic [VEC_W-1:0]                 vecA,
  input  logic [VEC_W-1:0]                 vecB,
  input  logic [VEC_W/MIN_LANE_W-1:0]      maskA,
  input  logic [VEC_W/MIN_LANE_W-1:0]      maskB,
  input  logic [SCALAR_W-1:0]              scalarIn,
  output logic                             outValid,
  output logic [VEC_W/MIN_LANE_W-1:0]      outMask,
  output logic                             outBit,
  output logic [VEC_W-1:0]                 outVec
);

  lcrStrobe_t strb;

  lcr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strb     (strb),
    .outValid (outValid)
  );

  lcr_datapath #(
    .VEC_W      (VEC_W),
    .MIN_LANE_W (MIN_LANE_W),
    .NUM_SIZES  (NUM_SIZES),
    .SCALAR_W   (SCALAR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .laneSize  (laneSize),
    .signedCmp (signedCmp),
    .vecA      (vecA),
    .vecB      (vecB),
    .maskA     (maskA),
    .maskB     (maskB),
    .scalarIn  (scalarIn),
    .outMask   (outMask),
    .outBit    (outBit),
    .outVec    (outVec)
  );

endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int NUM_SIZES  = 4,
  parameter int SCALAR_W   = 32,
  localparam int MASK_W    = VEC_W / MIN_LANE_W,
  localparam int SZ_W      = $clog2(NUM_SIZES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opSel,
  input logic [SZ_W-1:0]   laneSize,
  input logic [VEC_W-1:0]  vecA,
  input logic [VEC_W-1:0]  vecB,
  input logic [SCALAR_W-1:0] scalarIn,
  input logic              outValid,
  input logic [MASK_W-1:0] outMask,
  input logic              outBit,
  input logic [VEC_W-1:0]  outVec
);

  logic [SZ_W-1:0] sizeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sizeQ <= '0;
    else if (inValid) sizeQ <= laneSize;
  end

  function automatic logic [MASK_W-1:0] liveOf(input logic [SZ_W-1:0] sz);
    return {MASK_W{1'b1}} >> (MASK_W - (MASK_W >> sz));
  endfunction

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outMask & ~liveOf(sizeQ)) == '0));
  // R4
  ne_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd1 && vecA == vecB) |=> (outMask == '0));
  // R7
  bit_only_reduce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel != 4'd10 && opSel != 4'd11) |=> !outBit);
  // R8
  expand_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outVec[0] == outMask[0] &&
                  outVec[VEC_W-1] == outMask[(MASK_W >> sizeQ) - 1]));
  // R9
  splat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd13 && scalarIn == '0) |=> (outMask == '0));

endmodule

bind lane_cmp_unit lcr_checker #(
  .VEC_W      (VEC_W),
  .MIN_LANE_W (MIN_LANE_W),
  .NUM_SIZES  (NUM_SIZES),
  .SCALAR_W   (SCALAR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .laneSize (laneSize),
  .vecA     (vecA),
  .vecB     (vecB),
  .scalarIn (scalarIn),
  .outValid (outValid),
  .outMask  (outMask),
  .outBit   (outBit),
  .outVec   (outVec)
);

// File: tb/lane_cmp_unit_tb.sv
module lane_cmp_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   opSel = '0;
  logic [1:0]   laneSize = '0;
  logic         signedCmp = 1'b0;
  logic [127:0] vecA = '0, vecB = '0;
  logic [15:0]  maskA = '0, maskB = '0;
  logic [31:0]  scalarIn = '0;
  logic         outValid, outBit;
  logic [15:0]  outMask;
  logic [127:0] outVec;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit           v;
    logic [15:0]  m;
    logic         b;
    logic [127:0] vec;
    int           op;
    int           ls;
  } expect_t;
  expect_t pend[$];

  always #5 clk = ~clk;

  lane_cmp_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .laneSize(laneSize), .signedCmp(signedCmp), .vecA(vecA), .vecB(vecB),
    .maskA(maskA), .maskB(maskB), .scalarIn(scalarIn),
    .outValid(outValid), .outMask(outMask), .outBit(outBit), .outVec(outVec)
  );

  function automatic string tagOf(input int op);
    if (op <= 1)  return "R4";
    if (op <= 5)  return "R5";
    if (op <= 9)  return "R6";
    if (op <= 11) return "R7";
    if (op == 12) return "R8";
    if (op == 13) return "R9";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic refModel(input int op, input int ls, input bit sg,
                          input logic [127:0] a, input logic [127:0] b,
                          input logic [15:0] ma, input logic [15:0] mb,
                          input logic [31:0] sc, output expect_t e);
    int lanes;
    int lb;
    logic [63:0] lm, x, y, flip;
    logic [15:0] act;
    bit eq, lt;
    lanes = 16 >> ls;
    lb    = 8 << ls;
    lm    = {64{1'b1}} >> (64 - lb);
    flip  = 64'd1 << (lb - 1);
    act   = '0;
    e.v = 1'b1; e.m = '0; e.b = 1'b0; e.vec = '0; e.op = op; e.ls = ls;
    for (int i = 0; i < lanes; i++) act[i] = 1'b1;
    for (int i = 0; i < lanes; i++) begin
      x = 64'(a >> (i * lb)) & lm;
      y = 64'(b >> (i * lb)) & lm;
      eq = (x == y);
      // offset-binary trick: flipping sign bits maps signed order to unsigned
      if (sg) begin x = x ^ flip; y = y ^ flip; end
      lt = (x < y);
      case (op)
        0:  e.m[i] = eq;
        1:  e.m[i] = !eq;
        2:  e.m[i] = lt;
        3:  e.m[i] = lt || eq;
        4:  e.m[i] = !(lt || eq);
        5:  e.m[i] = !lt;
        6:  e.m[i] = ma[i] & mb[i];
        7:  e.m[i] = ma[i] | mb[i];
        8:  e.m[i] = ma[i] ^ mb[i];
        9:  e.m[i] = !ma[i];
        12: e.m[i] = ma[i];
        13: e.m[i] = (sc != 0);
        default: e.m[i] = 1'b0;
      endcase
    end
    if (op == 10) e.b = |(ma & act);
    if (op == 11) e.b = ((ma & act) == act);
    for (int j = 0; j < 128; j++) e.vec[j] = e.m[j / lb];
  endtask

  task automatic checkOut();
    expect_t e;
    logic [15:0] live;
    if (pend.size() == 0) return;
    e = pend.pop_front();
    chk(outValid == e.v, "R2", "valid", 128'(outValid), 128'(e.v));
    if (e.v) begin
      live = 16'hFFFF >> (16 - (16 >> e.ls));
      chk((outMask & ~live) == 0, "R3", "upper mask bits", 128'(outMask), 128'(outMask & live));
      chk(outMask == e.m, tagOf(e.op), "mask", 128'(outMask), 128'(e.m));
      chk(outBit == e.b, "R7", "reduce bit", 128'(outBit), 128'(e.b));
      chk(outVec == e.vec, "R8", "expanded vector", outVec, e.vec);
    end
  endtask

  task automatic issue(input bit vld, input int op, input int ls, input bit sg,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic [15:0] ma, input logic [15:0] mb,
                       input logic [31:0] sc);
    expect_t e;
    @(negedge clk);
    checkOut();
    inValid = vld; opSel = 4'(op); laneSize = 2'(ls); signedCmp = sg;
    vecA = a; vecB = b; maskA = ma; maskB = mb; scalarIn = sc;
    if (vld) refModel(op, ls, sg, a, b, ma, mb, sc, e);
    else begin e.v = 1'b0; e.m = '0; e.b = 1'b0; e.vec = '0; e.op = op; e.ls = ls; end
    pend.push_back(e);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(outValid == 0 && outMask == 0 && outBit == 0 && outVec == 0, "R1", "reset state",
        {outVec[127:18], outValid, outBit, outMask}, 128'd0);

    a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    // R4: equality ignores signedness, ne inverts
    issue(1, 0, 0, 0, a, a, 0, 0, 0);
    issue(1, 0, 0, 1, a, a, 0, 0, 0);
    issue(1, 1, 0, 1, a, a, 0, 0, 0);
    issue(1, 1, 2, 0, a, a ^ 128'h1, 0, 0, 0);
    // R5: sign boundary, 0x80 vs 0x7f
    issue(1, 2, 0, 1, {16{8'h80}}, {16{8'h7F}}, 0, 0, 0);
    issue(1, 2, 0, 0, {16{8'h80}}, {16{8'h7F}}, 0, 0, 0);
    issue(1, 5, 3, 1, {64'h8000_0000_0000_0000, 64'd5}, {64'd1, 64'd5}, 0, 0, 0);
    issue(1, 3, 2, 0, {32'd1, 32'd2, 32'hFFFF_FFFF, 32'd0}, {32'd1, 32'd1, 32'd0, 32'd7}, 0, 0, 0);
    issue(1, 4, 1, 1, {8{16'hFFFF}}, {8{16'h0001}}, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: mask logic with stray high bits
    issue(1, 6, 3, 0, 0, 0, 16'hFFFD, 16'hFFFF, 0);
    issue(1, 7, 2, 0, 0, 0, 16'hF0A1, 16'h0F02, 0);
    issue(1, 8, 1, 0, 0, 0, 16'hFF5A, 16'h00FF, 0);
    issue(1, 9, 3, 0, 0, 0, 16'hFFFE, 0, 0);
    // R7: reductions limited to active lanes
    issue(1, 10, 3, 0, 0, 0, 16'hFFFC, 0, 0);
    issue(1, 11, 3, 0, 0, 0, 16'h0003, 0, 0);
    issue(1, 11, 0, 0, 0, 0, 16'h7FFF, 0, 0);
    issue(1, 11, 0, 0, 0, 0, 16'hFFFF, 0, 0);
    issue(1, 10, 1, 0, 0, 0, 16'h0100, 0, 0);
    // R8: pass-through and expansion
    issue(1, 12, 1, 0, 0, 0, 16'hFFA5, 0, 0);
    issue(1, 12, 0, 0, 0, 0, 16'h8001, 0, 0);
    // R9: splat
    issue(1, 13, 2, 0, 0, 0, 0, 0, 32'h0000_0100);
    issue(1, 13, 0, 0, 0, 0, 0, 0, 32'h0);
    issue(1, 13, 3, 0, 0, 0, 0, 0, 32'h8000_0000);
    // R10: unused codes
    issue(1, 14, 0, 0, a, a, 16'hFFFF, 16'hFFFF, 32'h1);
    issue(1, 15, 1, 1, a, ~a, 16'hFFFF, 16'hFFFF, 32'h1);

    for (int n = 0; n < 600; n++) begin
      a = rnd128();
      case ($urandom % 4)
        0: b = a;
        1: b = rnd128();
        default: b = a ^ (rnd128() & rnd128() & rnd128() & rnd128() & rnd128());
      endcase
      issue(($urandom % 5) != 0, int'($urandom % 16), int'($urandom % 4), 1'($urandom),
            a, b, 16'($urandom), 16'($urandom),
            (($urandom % 3) == 0) ? 32'd0 : $urandom);
    end
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule